// File: doc/BRIEF.md
# Down-Counting Interval Timer with Compare Match

This block is a 16-bit timer that only counts downward. Software programs it through eight byte-wide registers: two counter bytes, two compare bytes, a control/status byte, a compare-enable byte and two mode bytes. The mode bytes pick the count clock. When the counter passes zero it reloads, sets a sticky underflow flag and pulses an interrupt. When the counter meets the compare value it sets a second sticky flag and pulses a second interrupt.

Software never starts or stops the count directly. It sets or clears a request bit. The timer answers through a separate status bit, which changes only on a count-enable cycle, and software polls that bit. The count enable is a single-cycle pulse in the bus clock domain. It comes from a bus-clock prescaler or from a slow tick input divided by a power of two.

The run control is a four-state machine. IDLE moves to ARM when the request is set. ARM moves back to IDLE if the request is withdrawn, and otherwise moves to RUN on a count enable. RUN moves to DISARM when the request is cleared. DISARM moves back to RUN if the request is set again, and otherwise moves to IDLE on a count enable. The status bit is 1 in RUN and DISARM. The counter only moves in RUN.

Register addresses: 0 counter low, 1 counter high, 2 compare low, 3 compare high, 4 control, 5 compare enable (bit 0), 6 clock select (bits 2:0), 7 slow divider exponent (bits 2:0). Control byte bits: bit 0 start request, bit 1 status (read-only), bit 5 underflow flag, bit 6 compare flag. Bits 7, 4, 3 and 2 read as 0.

Top module: `lp_downtimer`

## Requirements
- R1: After reset, the counter and compare registers read 0xFFFF, the control byte reads 0x00, the clock select reads 0, and both interrupt outputs are low.
- R2: The status bit (control bit 1) changes to match the start request (control bit 0) only on a count-enable cycle. While no count enable occurs, it keeps its old value.
- R3: The counter decrements by exactly one per count enable, and only while the status is 1 and the request is still set. In the arming and disarming phases it holds its value.
- R4: Each count enable at zero reloads the counter from the reload value, sets control bit 5 and raises irq_under for one cycle. A loaded value of N-1 therefore gives one underflow every N count enables.
- R5: When compare enable bit 0 is 1, a count enable at which the counter equals the compare value sets control bit 6 and raises irq_cmpa for one cycle. When the enable is 0, neither happens.
- R6: A control write of 0 to bit 5 or bit 6 clears that flag, and a write of 1 leaves it unchanged. If a hardware set and a clearing write fall in the same cycle, the flag ends up set.
- R7: Writing 0x00 to the control byte clears both flags at once. The status then drops at the next count enable, and the counter holds after that.
- R8: Clock select 0 counts on every bus cycle, 1 on every 8th cycle and 3 on every 2nd cycle. Select 4 uses the slow tick input. Selects 2, 5, 6 and 7 give no count enable, so the timer never leaves arming.
- R9: With select 4, the count enable fires on every 2^n-th slow tick, where n is the value in mode byte 2.
- R10: While the status is 1, a counter write changes only the reload value, and the new value takes effect at the next underflow. While the status is 0, the write loads the counter and the reload value together. Compare writes follow the same rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| slow_tick | input | 1 | One-cycle pulse from the low-speed clock source |
| irq_under | output | 1 | One-cycle underflow interrupt |
| irq_cmpa | output | 1 | One-cycle compare-match interrupt |

## Verification
The collision that matters is a software write that clears the underflow flag landing in the same clock as a hardware underflow that sets it. The bench runs at divide-by-1 with a known period. It waits for one underflow, clears the flag and confirms that it reads 0. It then counts cycles so that the next clearing write is captured on exactly the edge of the next underflow. The check passes if, after that edge, the interrupt is high and the flag still reads 1. A later write that keeps the flag bit at 1 must also leave the flag set.

// File: rtl/lp_downtimer_pkg.sv
package lp_downtimer_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_ARM,
        RS_RUN,
        RS_DISARM
    } run_state_e;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMPEN  = 3'd5;
    localparam logic [ADDR_W-1:0] A_MODE1  = 3'd6;
    localparam logic [ADDR_W-1:0] A_MODE2  = 3'd7;

    localparam int B_START = 0;
    localparam int B_STAT  = 1;
    localparam int B_UNDER = 5;
    localparam int B_CMPA  = 6;

    localparam logic [2:0] CS_DIV1 = 3'd0;
    localparam logic [2:0] CS_DIV8 = 3'd1;
    localparam logic [2:0] CS_DIV2 = 3'd3;
    localparam logic [2:0] CS_SLOW = 3'd4;

endpackage

// File: rtl/lp_downtimer_presc.sv
module lp_downtimer_presc
    import lp_downtimer_pkg::*;
#(
    parameter int SDIV_W = 3,
    parameter int FAST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        csel,
    input  logic [SDIV_W-1:0] sdiv,
    input  logic              slow_tick,
    output logic              cnt_en
);
    localparam int SLOW_W = (1 << SDIV_W) - 1;

    logic [FAST_W-1:0] fast_q;
    logic [SLOW_W-1:0] slow_q;
    logic [SLOW_W-1:0] slow_mask;
    logic              slow_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q <= '0;
            slow_q <= '0;
        end else begin
            fast_q <= fast_q + FAST_W'(1);
            if (slow_tick) begin
                slow_q <= slow_q + SLOW_W'(1);
            end
        end
    end

    assign slow_mask = ~({SLOW_W{1'b1}} << sdiv);
    assign slow_hit  = slow_tick && ((slow_q & slow_mask) == slow_mask);

    always_comb begin
        unique case (csel)
            CS_DIV1: cnt_en = 1'b1;
            CS_DIV8: cnt_en = &fast_q;
            CS_DIV2: cnt_en = fast_q[0];
            CS_SLOW: cnt_en = slow_hit;
            default: cnt_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/lp_downtimer_runctl.sv
module lp_downtimer_runctl
    import lp_downtimer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic cnt_en,
    output logic status,
    output logic run
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: begin
                if (start_req) state_d = RS_ARM;
            end
            RS_ARM: begin
                if (!start_req)  state_d = RS_IDLE;
                else if (cnt_en) state_d = RS_RUN;
            end
            RS_RUN: begin
                if (!start_req) state_d = RS_DISARM;
            end
            RS_DISARM: begin
                if (start_req)   state_d = RS_RUN;
                else if (cnt_en) state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        status = 1'b0;
        run    = 1'b0;
        unique case (state_q)
            RS_IDLE:   status = 1'b0;
            RS_ARM:    status = 1'b0;
            RS_RUN:    begin status = 1'b1; run = 1'b1; end
            RS_DISARM: status = 1'b1;
            default:   status = 1'b0;
        endcase
    end

endmodule

// File: rtl/lp_downtimer_core.sv
module lp_downtimer_core
    import lp_downtimer_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            stopped,
    input  logic            cnt_en,
    input  logic [CW/8-1:0] cnt_wr,
    input  logic [CW/8-1:0] cmp_wr,
    input  logic [7:0]      wbyte,
    input  logic            cmpa_en,
    input  logic            flag_wr,
    input  logic            keep_under,
    input  logic            keep_cmpa,
    output logic [CW-1:0]   count,
    output logic [CW-1:0]   cmp_view,
    output logic            flag_under,
    output logic            flag_cmpa,
    output logic            irq_under,
    output logic            irq_cmpa
);
    localparam int NB = CW / 8;

    logic [CW-1:0] count_q, reload_q, cmp_buf_q, cmp_act_q;
    logic [CW-1:0] reload_nx, load_nx, cmp_nx;
    logic          tick, hit_zero, hit_cmp;

    for (genvar ln = 0; ln < NB; ln++) begin : g_lane
        assign reload_nx[ln*8 +: 8] = cnt_wr[ln] ? wbyte : reload_q[ln*8 +: 8];
        assign load_nx[ln*8 +: 8]   = cnt_wr[ln] ? wbyte : count_q[ln*8 +: 8];
        assign cmp_nx[ln*8 +: 8]    = cmp_wr[ln] ? wbyte : cmp_buf_q[ln*8 +: 8];
    end

    assign tick     = run && cnt_en;
    assign hit_zero = tick && (count_q == '0);
    assign hit_cmp  = tick && cmpa_en && (count_q == cmp_act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q    <= '1;
            reload_q   <= '1;
            cmp_buf_q  <= '1;
            cmp_act_q  <= '1;
            flag_under <= 1'b0;
            flag_cmpa  <= 1'b0;
            irq_under  <= 1'b0;
            irq_cmpa   <= 1'b0;
        end else begin
            reload_q  <= reload_nx;
            cmp_buf_q <= cmp_nx;

            if (hit_zero) begin
                count_q <= reload_q;
            end else if (tick) begin
                count_q <= count_q - CW'(1);
            end else if (stopped) begin
                count_q <= load_nx;
            end

            if (stopped) begin
                cmp_act_q <= cmp_nx;
            end else if (hit_zero) begin
                cmp_act_q <= cmp_buf_q;
            end

            flag_under <= hit_zero || (flag_under && (!flag_wr || keep_under));
            flag_cmpa  <= hit_cmp  || (flag_cmpa  && (!flag_wr || keep_cmpa));
            irq_under  <= hit_zero;
            irq_cmpa   <= hit_cmp;
        end
    end

    assign count    = count_q;
    assign cmp_view = cmp_buf_q;

endmodule

// File: rtl/lp_downtimer.sv
module lp_downtimer
    import lp_downtimer_pkg::*;
#(
    parameter int CW     = CNT_W,
    parameter int SDIV_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              slow_tick,
    output logic              irq_under,
    output logic              irq_cmpa
);
    localparam int NB = CW / 8;

    logic              start_req;
    logic              cmpa_en_q;
    logic [2:0]        csel_q;
    logic [SDIV_W-1:0] sdiv_q;
    logic              cnt_en, status, run;
    logic [CW-1:0]     count, cmp_view;
    logic              flag_under, flag_cmpa;
    logic              wr_ctrl;
    logic [NB-1:0]     cnt_wr, cmp_wr;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign cnt_wr  = {wr_en && (addr == A_CNT_HI), wr_en && (addr == A_CNT_LO)};
    assign cmp_wr  = {wr_en && (addr == A_CMP_HI), wr_en && (addr == A_CMP_LO)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_req <= 1'b0;
            cmpa_en_q <= 1'b0;
            csel_q    <= CS_DIV1;
            sdiv_q    <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTRL:  start_req <= wdata[B_START];
                A_CMPEN: cmpa_en_q <= wdata[0];
                A_MODE1: csel_q    <= wdata[2:0];
                A_MODE2: sdiv_q    <= wdata[SDIV_W-1:0];
                default: ;
            endcase
        end
    end

    lp_downtimer_presc #(.SDIV_W(SDIV_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .csel      (csel_q),
        .sdiv      (sdiv_q),
        .slow_tick (slow_tick),
        .cnt_en    (cnt_en)
    );

    lp_downtimer_runctl u_runctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .cnt_en    (cnt_en),
        .status    (status),
        .run       (run)
    );

    lp_downtimer_core #(.CW(CW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .stopped    (!status),
        .cnt_en     (cnt_en),
        .cnt_wr     (cnt_wr),
        .cmp_wr     (cmp_wr),
        .wbyte      (wdata),
        .cmpa_en    (cmpa_en_q),
        .flag_wr    (wr_ctrl),
        .keep_under (wdata[B_UNDER]),
        .keep_cmpa  (wdata[B_CMPA]),
        .count      (count),
        .cmp_view   (cmp_view),
        .flag_under (flag_under),
        .flag_cmpa  (flag_cmpa),
        .irq_under  (irq_under),
        .irq_cmpa   (irq_cmpa)
    );

    always_comb begin
        rdata = 8'h00;
        case (addr)
            A_CNT_LO: rdata = count[7:0];
            A_CNT_HI: rdata = count[15:8];
            A_CMP_LO: rdata = cmp_view[7:0];
            A_CMP_HI: rdata = cmp_view[15:8];
            A_CTRL: begin
                rdata[B_START] = start_req;
                rdata[B_STAT]  = status;
                rdata[B_UNDER] = flag_under;
                rdata[B_CMPA]  = flag_cmpa;
            end
            A_CMPEN: rdata = {7'd0, cmpa_en_q};
            A_MODE1: rdata = {5'd0, csel_q};
            A_MODE2: rdata = 8'(sdiv_q);
            default: rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/lp_downtimer_chk.sv
module lp_downtimer_chk
    import lp_downtimer_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              cnt_en,
    input logic              status,
    input logic              run,
    input logic              cmpa_en_q,
    input logic [CW-1:0]     count,
    input logic              irq_under,
    input logic              irq_cmpa
);

    // R2
    status_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(cnt_en));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_en) && !($past(wr_en) && ($past(addr) < 3'd2))) |-> $stable(count));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_en && run && (count != '0)) |-> (count == ($past(count) - CW'(1))));

    // R4
    under_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_under |-> ($past(count) == CW'(0)) && $past(run));

    // R5
    cmpa_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmpa |-> $past(cmpa_en_q) && $past(run));

endmodule

bind lp_downtimer lp_downtimer_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .cnt_en    (cnt_en),
    .status    (status),
    .run       (run),
    .cmpa_en_q (cmpa_en_q),
    .count     (count),
    .irq_under (irq_under),
    .irq_cmpa  (irq_cmpa)
);

// File: tb/lp_downtimer_test.sv
module lp_downtimer_test;
    import lp_downtimer_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       slow_tick;
    logic       slow_man = 1'b0;
    logic       slow_a = 1'b0;
    logic       slow_auto = 1'b0;
    logic       irq_under, irq_cmpa;

    int n_chk = 0;
    int n_err = 0;
    int cmpa_total = 0;
    int ph = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign slow_tick = slow_man | slow_a;

    lp_downtimer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .slow_tick (slow_tick),
        .irq_under (irq_under),
        .irq_cmpa  (irq_cmpa)
    );

    always @(negedge clk) begin
        if (slow_auto) begin
            ph = (ph == 3) ? 0 : ph + 1;
            slow_a = (ph == 0);
        end else begin
            slow_a = 1'b0;
        end
        if (irq_cmpa) cmpa_total = cmpa_total + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] lo, hi;
        rd(A_CNT_LO, lo);
        rd(A_CNT_HI, hi);
        v = int'({hi, lo});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_once();
        slow_man = 1'b1;
        @(negedge clk);
        slow_man = 1'b0;
    endtask

    task automatic wait_stat(input bit v, output bit ok);
        logic [7:0] d;
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            rd(A_CTRL, d);
            if (d[B_STAT] == v) begin
                ok = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic wait_under(output bit ok);
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (irq_under) begin
                ok = 1;
                break;
            end
        end
    endtask

    task automatic gap(output int g);
        bit ok;
        g = 0;
        wait_under(ok);
        if (ok) begin
            for (int i = 1; i <= 5000; i++) begin
                @(negedge clk);
                if (irq_under) begin
                    g = i;
                    break;
                end
            end
        end
    endtask

    task automatic halt();
        bit ok;
        wr(A_CTRL, 8'h00);
        wait_stat(1'b0, ok);
        chk("R7 stop reached", int'(ok), 1);
    endtask

    task automatic load(input logic [2:0] cs, input int val);
        halt();
        wr(A_MODE1, {5'd0, cs});
        wr(A_CNT_LO, val[7:0]);
        wr(A_CNT_HI, val[15:8]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        int v;
        rd_cnt(v);
        chk("R1 counter", v, 16'hFFFF);
        rd(A_CMP_LO, d); chk("R1 compare lo", int'(d), 8'hFF);
        rd(A_CMP_HI, d); chk("R1 compare hi", int'(d), 8'hFF);
        rd(A_CTRL, d);   chk("R1 control", int'(d), 0);
        rd(A_MODE1, d);  chk("R1 clock select", int'(d), 0);
        chk("R1 irq_under", int'(irq_under), 0);
        chk("R1 irq_cmpa", int'(irq_cmpa), 0);
    endtask

    task automatic t_divide(input logic [2:0] cs, input int mult);
        int g, v;
        logic [7:0] d;
        load(cs, 5);
        wr(A_CTRL, 8'h01);
        gap(g);
        chk("R8 underflow spacing", g, 6 * mult);
        rd_cnt(v);
        chk("R4 reload after underflow", v, 5);
        rd(A_CTRL, d);
        chk("R4 underflow flag", int'(d[B_UNDER]), 1);
    endtask

    task automatic t_reload();
        int g, v;
        bit ok;
        load(CS_DIV1, 4);
        wr(A_CTRL, 8'h01);
        wait_stat(1'b1, ok);
        chk("R2 status rises", int'(ok), 1);
        wr(A_CNT_LO, 8'd9);
        rd_cnt(v);
        chk("R10 running write not loaded", int'(v <= 4), 1);
        gap(g);
        chk("R10 new period after underflow", g, 10);
    endtask

    task automatic t_coincide();
        logic [7:0] d;
        bit ok;
        wait_under(ok);
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, d);
        chk("R6 write 0 clears underflow flag", int'(d[B_UNDER]), 0);
        idle(8);
        wr(A_CTRL, 8'h01);
        chk("R6 underflow on clearing edge", int'(irq_under), 1);
        rd(A_CTRL, d);
        chk("R6 set wins over clear", int'(d[B_UNDER]), 1);
        wr(A_CTRL, 8'h21);
        rd(A_CTRL, d);
        chk("R6 write 1 keeps flag", int'(d[B_UNDER]), 1);
    endtask

    task automatic t_compare();
        logic [7:0] d;
        int v, s0;
        bit ok;
        load(CS_DIV1, 19);
        wr(A_CMP_LO, 8'd12);
        wr(A_CMP_HI, 8'd0);
        wr(A_CMPEN, 8'd1);
        wr(A_CTRL, 8'h01);
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (irq_cmpa) begin
                ok = 1;
                break;
            end
        end
        chk("R5 compare interrupt", int'(ok), 1);
        rd_cnt(v);
        chk("R5 counter after match", v, 11);
        rd(A_CTRL, d);
        chk("R5 compare flag", int'(d[B_CMPA]), 1);
        wr(A_CMPEN, 8'd0);
        wr(A_CTRL, 8'h01);
        s0 = cmpa_total;
        idle(60);
        chk("R5 disabled no interrupt", cmpa_total - s0, 0);
        rd(A_CTRL, d);
        chk("R5 disabled no flag", int'(d[B_CMPA]), 0);
    endtask

    task automatic t_clear_all();
        logic [7:0] d;
        int v1, v2;
        bit ok;
        wait_under(ok);
        rd(A_CTRL, d);
        chk("R4 flag before clear", int'(d[B_UNDER]), 1);
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, d);
        chk("R7 flags and request cleared", int'(d & 8'h61), 0);
        wait_stat(1'b0, ok);
        chk("R7 status drops", int'(ok), 1);
        rd_cnt(v1);
        idle(10);
        rd_cnt(v2);
        chk("R7 counter holds", v2, v1);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        int v;
        load(3'd2, 100);
        wr(A_CTRL, 8'h01);
        idle(30);
        rd(A_CTRL, d);
        chk("R8 reserved select never runs", int'(d[B_STAT]), 0);
        rd_cnt(v);
        chk("R8 reserved select holds counter", v, 100);
        wr(A_CTRL, 8'h00);
        idle(2);
    endtask

    task automatic t_slow_sync();
        logic [7:0] d;
        int v;
        load(CS_SLOW, 7);
        wr(A_MODE2, 8'd0);
        wr(A_CTRL, 8'h01);
        idle(6);
        rd(A_CTRL, d);
        chk("R2 status waits for enable", int'(d[B_STAT]), 0);
        tick_once();
        rd(A_CTRL, d);
        chk("R2 status after enable", int'(d[B_STAT]), 1);
        rd_cnt(v);
        chk("R3 no count on arming enable", v, 7);
        tick_once();
        rd_cnt(v);
        chk("R3 one step per enable", v, 6);
        wr(A_CTRL, 8'hF0);
        idle(3);
        rd(A_CTRL, d);
        chk("R2 status held while stopping", int'(d[B_STAT]), 1);
        rd_cnt(v);
        chk("R3 no count while disarming", v, 6);
        tick_once();
        rd(A_CTRL, d);
        chk("R2 status drops on enable", int'(d[B_STAT]), 0);
    endtask

    task automatic t_slow_div();
        int g;
        load(CS_SLOW, 2);
        wr(A_MODE2, 8'd2);
        slow_auto = 1'b1;
        wr(A_CTRL, 8'h01);
        gap(g);
        chk("R9 slow divide by 4", g, 48);
        slow_auto = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_divide(CS_DIV1, 1);
        t_divide(CS_DIV8, 8);
        t_divide(CS_DIV2, 2);
        t_reload();
        t_coincide();
        t_compare();
        t_clear_all();
        t_reserved();
        t_slow_sync();
        t_slow_div();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule